// File: doc/BRIEF.md
# Dual-Reload PWM Generator with Gating

This block produces a pulse-width-modulated waveform from a down-counter clocked by an external count-source tick. When the counter underflows, it reloads from one of two registers, taking them in turn. One register sets the length of the low time and the other sets the length of the high time, so duty cycle and period can be programmed independently. An optional stretch mode lengthens every high time by half a count-source period. This gives a high-time divide ratio of n+1.5 instead of n+1.

The output can be gated by a companion timer. While gating is enabled and the companion is running, each companion underflow pulse flips the output between valid and forced low. The counter keeps running underneath the gate. When the run bit is cleared, the current phase still runs to its next underflow, and only then does the block stop.

The count source is described by two single-cycle strobes: `src_tick` marks the start of each source period and `src_half` marks its midpoint. The counter advances on both strobes, so it works in half-period units.

Top module: `pwm_dual_reload`

## Requirements
- R1: While `rst` is high and in the cycle after it is released with `run_en` low, `pwm_out` is 0 and the counter is idle.
- R2: With `pwm_en` set and `run_en` set, the output repeats two phases. The low phase lasts `lo_len`+1 source periods. The high phase lasts `hi_len`+1 source periods. Each underflow reloads the counter from the register for the opposite phase.
- R3: Every output level change that comes from a reload occurs in the clock cycle right after a cycle in which `src_tick` or `src_half` was high.
- R4: With `half_ext` set, the high phase lasts `hi_len`+1.5 source periods. The low phase is unchanged at `lo_len`+1 source periods.
- R5: With `half_ext` set and `hi_len` equal to 0, the high phase is timed as if `hi_len` were 1, giving 2.5 source periods.
- R6: With `gate_en` and `peer_run` both high, each `peer_uf` pulse flips the gate between valid and invalid. While the gate is invalid, `pwm_out` is held at 0, the counter keeps running, and later high phases stay on the original time grid.
- R7: When `peer_run` or `gate_en` goes low, the gate returns to valid in the next cycle and the ungated waveform comes back.
- R8: Clearing `run_en` during a phase does not cut that phase short. The block stops at the next underflow, drives `pwm_out` to 0, and produces no further high phases.
- R9: With `pwm_en` low, `pwm_out` stays 0 while the counter runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 1 | Count-source period strobe |
| src_half | input | 1 | Count-source half-period strobe |
| lo_len | input | 8 | Low-phase reload value |
| hi_len | input | 8 | High-phase reload value |
| pwm_en | input | 1 | Alternating-reload PWM mode |
| half_ext | input | 1 | Stretch high phase by half a source period |
| run_en | input | 1 | Run request; a clear takes effect at the next underflow |
| gate_en | input | 1 | Enable gating by companion underflow |
| peer_uf | input | 1 | Companion timer underflow pulse |
| peer_run | input | 1 | Companion timer running status |
| pwm_out | output | 1 | PWM output |

## Verification
The main function is swept over every pairing of low and high reload values from 0 to 3, each with the half-period stretch off and on. The measured high and low widths are compared against (n+1) and (n+1.5) source periods. This separates a reload taken from the wrong register, an off-by-one phase length, a stretch that steals time from the low phase, and a missing clamp of a zero high value. The alignment of each edge to a tick or half strobe shows whether the level changes in the cycle of the reload. Separate patterns cover three cases: gating pulses placed at arbitrary points, where the returning edges must land on the original period grid; cancellation through either the companion status or the gate enable; and a run clear issued in the middle of a high phase, where the high width must stay whole.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef struct packed {
        logic pwm_en;
        logic half_ext;
        logic run_en;
    } pwm_cfg_t;

    // Count of half-period events minus one for a phase of reload value v.
    // A high phase in stretch mode gets one extra half period and a floor of 1.
    function automatic int unsigned half_count(input int unsigned v,
                                               input logic ext,
                                               input logic high_ph);
        int unsigned n;
        n = v;
        if (high_ph && ext && n == 0)
            n = 1;
        return 2 * n + 1 + ((high_ph && ext) ? 1 : 0);
    endfunction

endpackage

// File: rtl/pwm_phase_ctr.sv
module pwm_phase_ctr
    import pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         src_tick,
    input  logic         src_half,
    input  pwm_cfg_t     cfg,
    input  logic [W-1:0] lo_len,
    input  logic [W-1:0] hi_len,
    output phase_e       phase,
    output logic         active
);
    localparam int CW = W + 2;

    logic [CW-1:0] cnt;
    logic          ev;
    logic          uf_evt;
    logic [CW-1:0] lo_load;
    logic [CW-1:0] hi_load;

    assign ev      = src_tick | src_half;
    assign uf_evt  = active && ev && (cnt == '0);
    assign lo_load = CW'(half_count(int'(lo_len), 1'b0, 1'b0));
    assign hi_load = CW'(half_count(int'(hi_len), cfg.half_ext, 1'b1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            phase  <= PH_LOW;
            active <= 1'b0;
        end else if (!active) begin
            if (cfg.run_en) begin
                active <= 1'b1;
                phase  <= PH_LOW;
                cnt    <= lo_load;
            end
        end else if (uf_evt) begin
            if (!cfg.run_en) begin
                active <= 1'b0;
                phase  <= PH_LOW;
                cnt    <= '0;
            end else if (cfg.pwm_en && phase == PH_LOW) begin
                phase <= PH_HIGH;
                cnt   <= hi_load;
            end else begin
                phase <= PH_LOW;
                cnt   <= lo_load;
            end
        end else if (ev) begin
            cnt <= cnt - 1'b1;
        end
    end

    a_r2_low_to_high: assert property (@(posedge clk) disable iff (rst)
        (active && cfg.pwm_en && cfg.run_en && uf_evt && phase == PH_LOW)
        |=> (phase == PH_HIGH));

    a_r5_clamped_high_load: assert property (@(posedge clk) disable iff (rst)
        (active && cfg.pwm_en && cfg.run_en && uf_evt && phase == PH_LOW)
        |=> (32'(cnt) == 2 * ((($past(hi_len) == 0) && $past(cfg.half_ext))
                                 ? 32'd1 : 32'($past(hi_len)))
                       + 1 + ($past(cfg.half_ext) ? 32'd1 : 32'd0)));

    a_r2_hold_between_events: assert property (@(posedge clk) disable iff (rst)
        (active && !ev) |=> $stable(cnt));

    a_r8_keep_running: assert property (@(posedge clk) disable iff (rst)
        (active && !uf_evt) |=> active);

    a_r8_stop_at_underflow: assert property (@(posedge clk) disable iff (rst)
        (active && uf_evt && !cfg.run_en) |=> (!active && phase == PH_LOW));

endmodule

// File: rtl/pwm_gate.sv
module pwm_gate (
    input  logic clk,
    input  logic rst,
    input  logic gate_en,
    input  logic peer_uf,
    input  logic peer_run,
    output logic gate_ok
);
    logic armed;

    assign armed = gate_en && peer_run;

    always_ff @(posedge clk) begin
        if (rst)
            gate_ok <= 1'b1;
        else if (!armed)
            gate_ok <= 1'b1;
        else if (peer_uf)
            gate_ok <= ~gate_ok;
    end

    a_r6_toggle_on_peer: assert property (@(posedge clk) disable iff (rst)
        (armed && peer_uf) |=> (gate_ok != $past(gate_ok)));

    a_r6_hold_without_peer: assert property (@(posedge clk) disable iff (rst)
        (armed && !peer_uf) |=> $stable(gate_ok));

    a_r7_cancel_gate: assert property (@(posedge clk) disable iff (rst)
        (!peer_run || !gate_en) |=> gate_ok);

endmodule

// File: rtl/pwm_dual_reload.sv
module pwm_dual_reload
    import pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         src_tick,
    input  logic         src_half,
    input  logic [W-1:0] lo_len,
    input  logic [W-1:0] hi_len,
    input  logic         pwm_en,
    input  logic         half_ext,
    input  logic         run_en,
    input  logic         gate_en,
    input  logic         peer_uf,
    input  logic         peer_run,
    output logic         pwm_out
);
    pwm_cfg_t cfg;
    phase_e   phase;
    logic     active;
    logic     gate_ok;

    assign cfg = '{pwm_en: pwm_en, half_ext: half_ext, run_en: run_en};

    pwm_phase_ctr #(.W(W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .src_tick (src_tick),
        .src_half (src_half),
        .cfg      (cfg),
        .lo_len   (lo_len),
        .hi_len   (hi_len),
        .phase    (phase),
        .active   (active)
    );

    pwm_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .gate_en  (gate_en),
        .peer_uf  (peer_uf),
        .peer_run (peer_run),
        .gate_ok  (gate_ok)
    );

    assign pwm_out = active && cfg.pwm_en && (phase == PH_HIGH) && gate_ok;

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        rst |=> !pwm_out);

    a_r6_gated_low: assert property (@(posedge clk) disable iff (rst)
        !gate_ok |-> !pwm_out);

endmodule

// File: tb/pwm_dual_reload_tb_top.sv
module pwm_dual_reload_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       src_tick = 1'b0;
    logic       src_half = 1'b0;
    logic [7:0] lo_len = 8'd0;
    logic [7:0] hi_len = 8'd0;
    logic       pwm_en = 1'b0;
    logic       half_ext = 1'b0;
    logic       run_en = 1'b0;
    logic       gate_en = 1'b0;
    logic       peer_uf = 1'b0;
    logic       peer_run = 1'b0;
    logic       pwm_out;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int rises = 0;
    int falls = 0;
    int len = 0;
    int hi_meas = 0;
    int lo_meas = 0;
    int rise_cyc = 0;
    bit align_on = 1'b1;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm_dual_reload dut_i (
        .clk      (clk),
        .rst      (rst),
        .src_tick (src_tick),
        .src_half (src_half),
        .lo_len   (lo_len),
        .hi_len   (hi_len),
        .pwm_en   (pwm_en),
        .half_ext (half_ext),
        .run_en   (run_en),
        .gate_en  (gate_en),
        .peer_uf  (peer_uf),
        .peer_run (peer_run),
        .pwm_out  (pwm_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Source strobes (period 4 clocks) and edge monitor, all at the falling edge.
    initial begin
        int ph;
        logic prev_o;
        ph = 0;
        prev_o = 1'b0;
        forever begin
            logic o;
            logic cur_ev;
            @(negedge clk);
            cyc++;
            o = pwm_out;
            cur_ev = src_tick | src_half;
            if (o !== prev_o) begin
                if (align_on)
                    chk(cur_ev, "R3 edge aligned to strobe", int'(cur_ev), 1);
                if (o) begin
                    rises++;
                    lo_meas = len;
                    rise_cyc = cyc;
                end else begin
                    falls++;
                    hi_meas = len;
                end
                len = 1;
            end else begin
                len++;
            end
            prev_o = o;
            ph = (ph + 1) % 4;
            src_tick = (ph == 0);
            src_half = (ph == 2);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic restart(input int lo, input int hi, input bit ext, input bit pm);
        @(negedge clk);
        rst = 1'b1;
        run_en = 1'b0;
        gate_en = 1'b0;
        peer_run = 1'b0;
        peer_uf = 1'b0;
        lo_len = 8'(lo);
        hi_len = 8'(hi);
        half_ext = ext;
        pwm_en = pm;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(pwm_out == 1'b0, "R1 idle after reset", int'(pwm_out), 0);
    endtask

    task automatic pulse_peer();
        @(negedge clk);
        peer_uf = 1'b1;
        @(negedge clk);
        peer_uf = 1'b0;
    endtask

    initial begin
        int r0;
        int r1;
        int f0;
        int refc;

        // R1: reset state
        repeat (2) @(negedge clk);
        chk(pwm_out == 1'b0, "R1 output low in reset", int'(pwm_out), 0);

        // R2, R4, R5: sweep of reload values and stretch mode
        for (int ext = 0; ext < 2; ext++) begin
            for (int lo = 0; lo < 4; lo++) begin
                for (int hi = 0; hi < 4; hi++) begin
                    int eh;
                    int exp_hi;
                    restart(lo, hi, ext[0], 1'b1);
                    r0 = rises;
                    run_en = 1'b1;
                    wait (rises >= r0 + 3);
                    eh = (ext == 1 && hi == 0) ? 1 : hi;
                    exp_hi = 4 * (eh + 1) + ((ext == 1) ? 2 : 0);
                    if (ext == 1 && hi == 0)
                        chk(hi_meas == exp_hi, "R5 zero high clamped", hi_meas, exp_hi);
                    else if (ext == 1)
                        chk(hi_meas == exp_hi, "R4 stretched high", hi_meas, exp_hi);
                    else
                        chk(hi_meas == exp_hi, "R2 high width", hi_meas, exp_hi);
                    chk(lo_meas == 4 * (lo + 1), "R2 R4 low width", lo_meas, 4 * (lo + 1));
                end
            end
        end

        // R9: plain mode keeps the output low
        restart(1, 1, 1'b0, 1'b0);
        r0 = rises;
        run_en = 1'b1;
        repeat (60) @(negedge clk);
        chk(rises == r0, "R9 no pulses without PWM mode", rises - r0, 0);

        // R8: run cleared mid high phase
        restart(2, 3, 1'b0, 1'b1);
        r0 = rises;
        run_en = 1'b1;
        wait (rises >= r0 + 2);
        repeat (5) @(negedge clk);
        f0 = falls;
        run_en = 1'b0;
        wait (falls > f0);
        chk(hi_meas == 16, "R8 high phase completes", hi_meas, 16);
        r1 = rises;
        repeat (60) @(negedge clk);
        chk(rises == r1, "R8 stopped after underflow", rises - r1, 0);
        chk(pwm_out == 1'b0, "R8 output low when stopped", int'(pwm_out), 0);

        // R6, R7: gating
        restart(1, 1, 1'b0, 1'b1);
        r0 = rises;
        run_en = 1'b1;
        wait (rises >= r0 + 2);
        refc = rise_cyc;
        align_on = 1'b0;
        @(negedge clk);
        gate_en = 1'b1;
        peer_run = 1'b1;
        pulse_peer();
        chk(pwm_out == 1'b0, "R6 gated output low", int'(pwm_out), 0);
        r1 = rises;
        repeat (40) @(negedge clk);
        chk(rises == r1, "R6 no pulses while gated", rises - r1, 0);
        pulse_peer();
        r1 = rises;
        wait (rises >= r1 + 2);
        chk(((rise_cyc - refc) % 16) == 0, "R6 counter ran while gated",
            (rise_cyc - refc) % 16, 0);

        pulse_peer();
        r1 = rises;
        repeat (20) @(negedge clk);
        chk(rises == r1, "R6 second gate-off", rises - r1, 0);
        peer_run = 1'b0;
        r1 = rises;
        repeat (20) @(negedge clk);
        chk(rises > r1, "R7 cancel by stopped peer", rises - r1, 1);

        peer_run = 1'b1;
        pulse_peer();
        r1 = rises;
        repeat (20) @(negedge clk);
        chk(rises == r1, "R6 gate-off again", rises - r1, 0);
        gate_en = 1'b0;
        r1 = rises;
        repeat (20) @(negedge clk);
        chk(rises > r1, "R7 cancel by gate disable", rises - r1, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule